// File: doc/BRIEF.md
# Programmable Width Frame Pulse Generator

The block divides a fast reference clock (nominally 155.52 MHz, about 6.43 ns per period) down to a low-rate frame pulse. With the default divide ratio of 19440 the output runs at 8 kHz. A second copy built with a ratio of 77760 gives 2 kHz and uses the same control encoding. A 6-bit control code picks one of three output modes: the output driver is released (high impedance), a narrow pulse lasting a chosen number of reference cycles at the start of each frame, or a square wave with equal high and low halves.

The control code sits in the low six bits of an 8-bit register, which is written through a single-cycle strobe with an address match and read back combinationally. A code written in the middle of a frame is staged. It becomes active at the next frame boundary, so the output never shows a shortened or lengthened pulse. The pulse and its output enable are registered, so the pad driver sees glitch-free edges. A frame-start flag marks the first cycle of every frame.

Top module: `frame_pulse_gen`

## Requirements
- R1: After reset the stored code is 63, a read of the control register returns 0x3F, the frame counter starts at 0 (frame_start high in the first cycle), and the output is high with pulse_oe asserted.
- R2: frame_start is high for exactly one cycle in every FRAME_LEN cycles. The frame counter steps by one and wraps from FRAME_LEN-1 to 0.
- R3: With code 0 active, pulse_oe is low and pulse_out is held low for the whole frame.
- R4: With a code N from 1 to 62 active, pulse_oe is high, and pulse_out is high for exactly N cycles starting with the frame_start cycle, then low until the frame ends.
- R5: With code 63 active, pulse_out is high for the first FRAME_LEN/2 cycles of the frame and low for the rest.
- R6: A code written during a frame does not change the output in that frame. It becomes active in the first cycle of the next frame.
- R7: The stored code changes only when reg_wr is high and reg_addr equals REG_ADDR in the same cycle. A write to another address, or data presented without the strobe, leaves it unchanged.
- R8: A write stores reg_wdata[5:0] and discards bits 7:6. With reg_addr equal to REG_ADDR, reg_rdata returns {2'b00, stored code}.
- R9: The extreme narrow widths 1 and 62 each give a pulse of exactly that many cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | 8 | Write data; bits 5:0 hold the code |
| reg_rdata | output | 8 | Read data; {2'b00, code} on address match, else 0 |
| pulse_out | output | 1 | Frame pulse level (low while disabled) |
| pulse_oe | output | 1 | Output enable for the pad driver; low means high impedance |
| frame_start | output | 1 | High in the first cycle of each frame |

## Verification
Assertions check, on every cycle, the following properties:
- the counter step and wrap;
- that the active code stays stable everywhere except at a frame boundary;
- that the output stays low while the enable is off;
- that every rising edge of the pulse lands on the frame start;
- that every falling edge lands at the cycle that the active code or the half-frame point predicts;
- that the stored code ignores writes that are not addressed to it.

The exact per-cycle waveform of each whole frame for codes 0, 1, 7, 5, 62 and 63 can only be shown by the bench's scenarios. The same holds for the following behaviours:
- the deferral of a mid-frame write to the next boundary;
- the masking of the upper data bits;
- the read-back value.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    localparam int CODE_W = 6;
    localparam int REG_W  = 8;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t CODE_OFF    = code_t'(0);
    localparam code_t CODE_SQUARE = code_t'(63);

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_NARROW,
        MODE_SQUARE
    } mode_e;

    function automatic mode_e decode_mode(input code_t code);
        if (code == CODE_OFF) begin
            return MODE_OFF;
        end else if (code == CODE_SQUARE) begin
            return MODE_SQUARE;
        end
        return MODE_NARROW;
    endfunction

endpackage

// File: rtl/fpg_ctrl_reg.sv
module fpg_ctrl_reg
    import fpg_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output code_t             code_o
);

    typedef struct packed {
        code_t code;
    } reg_st_t;

    reg_st_t st_d;
    reg_st_t st_q;
    logic    hit;
    logic    unused_wdata_hi;

    assign hit             = (addr == REG_ADDR);
    assign unused_wdata_hi = ^wdata[REG_W-1:CODE_W];

    always_comb begin
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.code = wdata[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= CODE_SQUARE;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign rdata  = hit ? {{(REG_W-CODE_W){1'b0}}, st_q.code} : '0;

    AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == REG_ADDR)) |=> $stable(code_o)); // R7

    AST_WR_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == REG_ADDR)) |=> (code_o == $past(wdata[CODE_W-1:0]))); // R8

endmodule

// File: rtl/fpg_frame_counter.sv
module fpg_frame_counter #(
    parameter int  FRAME_LEN = 19440,
    localparam int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nxt_o,
    output logic             first_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d;
    cnt_st_t st_q;
    logic    at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt == LAST);
        if (at_last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.cnt;
    assign count_nxt_o = st_d.cnt;
    assign first_o     = (st_q.cnt == '0);
    assign last_o      = at_last;

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == LAST) |=> (count_o == '0)); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != LAST) |=> (count_o == $past(count_o) + CNT_W'(1))); // R2

endmodule

// File: rtl/fpg_pulse_shaper.sv
module fpg_pulse_shaper
    import fpg_pkg::*;
#(
    parameter int  FRAME_LEN = 19440,
    localparam int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] count_nxt_i,
    input  logic             frame_last_i,
    input  code_t            code_i,
    output logic             pulse_o,
    output logic             oe_o
);

    localparam logic [CNT_W-1:0] HALF = CNT_W'(FRAME_LEN / 2);

    typedef struct packed {
        code_t act;
        logic  oe;
        logic  pulse;
    } shp_st_t;

    shp_st_t st_d;
    shp_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (frame_last_i) begin
            st_d.act = code_i;
        end
        unique case (decode_mode(st_d.act))
            MODE_OFF: begin
                st_d.oe    = 1'b0;
                st_d.pulse = 1'b0;
            end
            MODE_NARROW: begin
                st_d.oe    = 1'b1;
                st_d.pulse = (count_nxt_i < CNT_W'(st_d.act));
            end
            default: begin
                st_d.oe    = 1'b1;
                st_d.pulse = (count_nxt_i < HALF);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act   <= CODE_SQUARE;
            st_q.oe    <= 1'b1;
            st_q.pulse <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;
    assign oe_o    = st_q.oe;

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_last_i |=> $stable(st_q.act)); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_o |-> !pulse_o); // R3

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> (count_i == '0)); // R4

    AST_NARROW_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_o) && (st_q.act != CODE_SQUARE)) |-> (count_i == CNT_W'(st_q.act))); // R4

    AST_SQUARE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_o) && (st_q.act == CODE_SQUARE)) |-> (count_i == HALF)); // R5

endmodule

// File: rtl/frame_pulse_gen.sv
module frame_pulse_gen
    import fpg_pkg::*;
#(
    parameter int                FRAME_LEN = 19440,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              pulse_out,
    output logic              pulse_oe,
    output logic              frame_start
);

    localparam int CNT_W = $clog2(FRAME_LEN);

    code_t            staged_code;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_nxt;
    logic             frame_last;

    fpg_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) i_ctrl_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .code_o (staged_code)
    );

    fpg_frame_counter #(
        .FRAME_LEN (FRAME_LEN)
    ) i_frame_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_o     (count),
        .count_nxt_o (count_nxt),
        .first_o     (frame_start),
        .last_o      (frame_last)
    );

    fpg_pulse_shaper #(
        .FRAME_LEN (FRAME_LEN)
    ) i_pulse_shaper (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_i      (count),
        .count_nxt_i  (count_nxt),
        .frame_last_i (frame_last),
        .code_i       (staged_code),
        .pulse_o      (pulse_out),
        .oe_o         (pulse_oe)
    );

    AST_FRAME_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start); // R2

endmodule

// File: tb/test_frame_pulse_gen.sv
module test_frame_pulse_gen;

    localparam int         FL       = 160;
    localparam logic [7:0] REG_ADDR = 8'h12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pulse_out;
    logic       pulse_oe;
    logic       frame_start;

    int total = 0;
    int fails = 0;

    typedef struct {
        logic  oe;
        logic  pv;
        logic  fs;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    frame_pulse_gen #(
        .FRAME_LEN (FL),
        .ADDR_W    (8),
        .REG_ADDR  (REG_ADDR)
    ) i_frame_pulse_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pulse_out   (pulse_out),
        .pulse_oe    (pulse_oe),
        .frame_start (frame_start)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // driver: one full frame of expected outputs for a given active code
    task automatic run_frame(input int code, input string tag);
        for (int k = 0; k < FL; k++) begin
            exp_t e;
            e.fs  = (k == 0);
            e.tag = tag;
            if (code == 0) begin
                e.oe = 1'b0;
                e.pv = 1'b0;
            end else if (code == 63) begin
                e.oe = 1'b1;
                e.pv = (k < FL / 2);
            end else begin
                e.oe = 1'b1;
                e.pv = (k < code);
            end
            exp_q.push_back(e);
        end
        wait (exp_q.size() == 0);
    endtask

    // monitor: starts on a frame start, pops one item per cycle
    initial begin
        bit live = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                if (!live && frame_start) live = 1'b1;
                if (live) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk((pulse_out === e.pv) && (pulse_oe === e.oe), e.tag,
                        "pulse/oe", {pulse_oe, pulse_out}, {e.oe, e.pv});
                    chk(frame_start === e.fs, "R2", "frame_start", frame_start, e.fs);
                    if (exp_q.size() == 0) live = 1'b0;
                end
            end
        end
    end

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input logic w);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = w;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic read_chk(input logic [7:0] expv, input string tag);
        reg_addr = REG_ADDR;
        #1;
        chk(reg_rdata === expv, tag, "rdata", reg_rdata, expv);
    endtask

    task automatic set_code(input logic [7:0] d);
        do @(negedge clk); while (!frame_start);
        repeat (10) @(negedge clk);
        reg_write(REG_ADDR, d, 1'b1);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(frame_start === 1'b1, "R1", "frame_start", frame_start, 1);
        chk(pulse_out === 1'b1, "R1", "pulse_out", pulse_out, 1);
        chk(pulse_oe === 1'b1, "R1", "pulse_oe", pulse_oe, 1);
        read_chk(8'h3F, "R1");

        run_frame(63, "R5");

        // R6: mid-frame write must not disturb the running square frame
        set_code(8'd5);
        #1;
        chk(pulse_out === 1'b1, "R6", "pulse_out early", pulse_out, 1);
        read_chk(8'h05, "R8");
        repeat (89) @(negedge clk);
        #1;
        chk(pulse_out === 1'b0, "R6", "pulse_out late", pulse_out, 0);
        run_frame(5, "R4");

        set_code(8'd1);
        run_frame(1, "R9");
        set_code(8'd62);
        run_frame(62, "R9");
        set_code(8'd0);
        run_frame(0, "R3");

        // R8: upper data bits are discarded
        set_code(8'hC7);
        read_chk(8'h07, "R8");
        run_frame(7, "R8");

        // R7: wrong address and missing strobe
        reg_write(8'h13, 8'h0A, 1'b1);
        read_chk(8'h07, "R7");
        reg_write(REG_ADDR, 8'h0A, 1'b0);
        read_chk(8'h07, "R7");
        run_frame(7, "R7");

        set_code(8'd63);
        read_chk(8'h3F, "R8");
        run_frame(63, "R5");

        finish_run();
    end

endmodule